// File: doc/BRIEF.md
# Character FIFO with Threshold Interrupt

This block is a sixteen-entry buffer of 8-bit characters placed between the shift logic of a serial port and the register interface a host processor sees. A design uses two copies: a receive copy, filled by the deserializer and drained by host reads, and a transmit copy, filled by host writes and drained by the serializer. Each copy takes characters in through a push strobe and hands them out through a pop strobe. It reports its live fill count as a 5-bit value and a space-available flag. The host polls the space-available flag before writing a character, and it polls for a nonzero count before reading one.

Each copy holds a programmable 5-bit threshold. A parameter selects the direction, and the direction selects the comparison. A receive copy flags when the count has climbed to the threshold or above. A transmit copy flags when the count has fallen to the threshold or below. The receive threshold resets to 31. The count can never reach 31, so an idle receive buffer never raises a request.

Each copy also has its own enable input, its own interrupt mask and a hold-in-clear control. It keeps a sticky overflow flag for characters lost to a full buffer.

Top module: `char_fifo_irq`

## Requirements
- R1: After `rst_n` is low, `fill` is 0 and `space_ok` is 1. `ovf_flag`, `irq` and `pop_data` are 0. `level_q` is 31 (5'b11111) in a receive copy and 0 in a transmit copy.
- R2: Characters leave in the order they were accepted. An accepted pop presents the oldest character on `pop_data` one clock after the pop strobe is sampled.
- R3: `fill` equals the accepted pushes minus the accepted pops and stays within 0..16. `space_ok` is 1 exactly when `fill` is below 16.
- R4: A push sampled at a full count with no accepted pop is dropped and sets `ovf_flag` on the next clock. A one on `ovf_clr` clears the flag. A same-cycle overflow wins over the clear.
- R5: A pop sampled at a count of 0 leaves `pop_data` at the last character read and leaves `fill` at 0.
- R6: A push and a pop in the same cycle behave as follows. At a full count both are accepted and `fill` stays 16. At a count of 0 only the push is accepted and `fill` becomes 1.
- R7: While `dir_en` is 0, `push` and `pop` are ignored.
- R8: While `fifo_run` is 0, the buffer is held cleared. `fill` is 0, pushes and pops are ignored, and `ovf_flag` and the internal request flag are cleared. The stored threshold is kept.
- R9: A receive copy (IS_TX=0) sets its request flag one clock after it samples `fill >= level_q`. With the reset threshold of 31 it never does.
- R10: A transmit copy (IS_TX=1) sets its request flag one clock after it samples `fill <= level_q`.
- R11: `irq` is the request flag ANDed with `irq_en`. A one on `irq_clr` clears the flag at the next clock. The flag sets again one clock later if the condition still holds.
- R12: A one on `level_we` loads `level_wdata` into `level_q` at the next clock, whether or not `fifo_run` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_run | input | 1 | 1 releases the buffer; 0 holds it cleared |
| dir_en | input | 1 | Enables the push and pop strobes |
| irq_en | input | 1 | Interrupt mask, 1 passes the request flag |
| irq_clr | input | 1 | Clears the request flag |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| level_we | input | 1 | Loads a new threshold |
| level_wdata | input | 5 | Threshold value to load |
| level_q | output | 5 | Current threshold |
| push | input | 1 | Push strobe |
| push_data | input | 8 | Character to push |
| pop | input | 1 | Pop strobe |
| pop_data | output | 8 | Last character popped |
| fill | output | 5 | Live fill count, 0..16 |
| space_ok | output | 1 | 1 when a push would be accepted |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Masked interrupt request |

## Verification
Push and pop can land in the same cycle. The two extremes of the count are where that matters. The bench drives both strobes together at a count of 16 and at a count of 0. At 16 it expects the count to hold and the overflow flag to stay clear. At 0 it expects the count to reach 1 and the read data to stay unchanged. The overflow event and its clear are also driven in one cycle, and the bench expects the flag to stay set. Throughout a threshold sweep, `irq_clr` pulses while the condition still holds, and the bench judges `irq` against a model that rebuilds the request flag from the count and threshold sampled before each edge.

// File: rtl/char_fifo_pkg.sv
package char_fifo_pkg;

  // Ring pointer advance with wrap at the buffer depth.
  function automatic int ptr_next(int p, int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // Fill count after one cycle of accepted push/pop.
  function automatic int count_next(int c, bit up, bit dn);
    return c + (up ? 1 : 0) - (dn ? 1 : 0);
  endfunction

  // Threshold comparison: transmit flags at or below, receive at or above.
  function automatic bit level_hit(int c, int lvl, bit is_tx);
    return is_tx ? (c <= lvl) : (c >= lvl);
  endfunction

endpackage

// File: rtl/cfifo_store.sv
module cfifo_store
  import char_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          wr_go,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_go,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (wr_go) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (hold) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_go) wptr <= AW'(ptr_next(int'(wptr), DEPTH));
      if (rd_go) rptr <= AW'(ptr_next(int'(rptr), DEPTH));
    end
  end

  // Read data register keeps the last popped character.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_go) rd_data <= mem[rptr];
  end

endmodule

// File: rtl/cfifo_ctrl.sv
module cfifo_ctrl
  import char_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter bit IS_TX = 1'b0,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          dir_en,
  input  logic          push,
  input  logic          pop,
  input  logic          level_we,
  input  logic [CW-1:0] level_wdata,
  output logic [CW-1:0] level_q,
  output logic [CW-1:0] fill,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          ovf_evt,
  output logic          lvl_cond
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] LVL_RST  = IS_TX ? '0 : '1;

  logic is_full, is_empty, live;

  assign is_full  = (fill == FULL_CNT);
  assign is_empty = (fill == '0);
  assign live     = !hold && dir_en;

  assign pop_ok   = live && pop && !is_empty;
  assign push_ok  = live && push && (!is_full || pop_ok);
  assign ovf_evt  = live && push && is_full && !pop_ok;
  assign lvl_cond = level_hit(int'(fill), int'(level_q), IS_TX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    fill <= '0;
    else if (hold) fill <= '0;
    else           fill <= CW'(count_next(int'(fill), push_ok, pop_ok));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        level_q <= LVL_RST;
    else if (level_we) level_q <= level_wdata;
  end

endmodule

// File: rtl/cfifo_flags.sv
module cfifo_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic lvl_cond,
  input  logic irq_clr,
  input  logic irq_en,
  input  logic ovf_evt,
  input  logic ovf_clr,
  output logic req_flag,
  output logic ovf_flag,
  output logic irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        req_flag <= 1'b0;
    else if (hold)     req_flag <= 1'b0;
    else if (irq_clr)  req_flag <= 1'b0;
    else if (lvl_cond) req_flag <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (hold)    ovf_flag <= 1'b0;
    else if (ovf_evt) ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;
  end

  assign irq = req_flag && irq_en;

endmodule

// File: rtl/char_fifo_irq.sv
module char_fifo_irq #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter bit IS_TX = 1'b0,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_run,
  input  logic          dir_en,
  input  logic          irq_en,
  input  logic          irq_clr,
  input  logic          ovf_clr,
  input  logic          level_we,
  input  logic [CW-1:0] level_wdata,
  output logic [CW-1:0] level_q,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] fill,
  output logic          space_ok,
  output logic          ovf_flag,
  output logic          irq
);

  // Named internal events, observed by the bound checker.
  logic hold, push_ok, pop_ok, ovf_evt, lvl_cond, req_flag;

  assign hold     = !fifo_run;
  assign space_ok = (fill != CW'(DEPTH));

  cfifo_ctrl #(.DEPTH(DEPTH), .IS_TX(IS_TX)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .dir_en     (dir_en),
    .push       (push),
    .pop        (pop),
    .level_we   (level_we),
    .level_wdata(level_wdata),
    .level_q    (level_q),
    .fill       (fill),
    .push_ok    (push_ok),
    .pop_ok     (pop_ok),
    .ovf_evt    (ovf_evt),
    .lvl_cond   (lvl_cond)
  );

  cfifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (hold),
    .wr_go  (push_ok),
    .wr_data(push_data),
    .rd_go  (pop_ok),
    .rd_data(pop_data)
  );

  cfifo_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (hold),
    .lvl_cond(lvl_cond),
    .irq_clr (irq_clr),
    .irq_en  (irq_en),
    .ovf_evt (ovf_evt),
    .ovf_clr (ovf_clr),
    .req_flag(req_flag),
    .ovf_flag(ovf_flag),
    .irq     (irq)
  );

endmodule

// File: rtl/char_fifo_chk.sv
module char_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_run,
  input logic          dir_en,
  input logic          pop,
  input logic          irq_en,
  input logic [CW-1:0] fill,
  input logic [DW-1:0] pop_data,
  input logic          ovf_flag,
  input logic          irq,
  input logic          push_ok,
  input logic          pop_ok,
  input logic          ovf_evt
);

  // R3
  fill_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag);

  // R5
  empty_pop_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && dir_en && fill == '0) |=> $stable(pop_data));

  // R6
  both_ops_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> $stable(fill));

  // R7
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_en && fifo_run) |=> $stable(fill));

  // R8
  run_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_run |=> (fill == '0 && !ovf_flag));

  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);

endmodule

bind char_fifo_irq char_fifo_chk #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .fifo_run(fifo_run),
  .dir_en  (dir_en),
  .pop     (pop),
  .irq_en  (irq_en),
  .fill    (fill),
  .pop_data(pop_data),
  .ovf_flag(ovf_flag),
  .irq     (irq),
  .push_ok (push_ok),
  .pop_ok  (pop_ok),
  .ovf_evt (ovf_evt)
);

// File: tb/tb_char_fifo_irq.sv
module tb_char_fifo_irq;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_run = 1'b0, dir_en = 1'b0, irq_en = 1'b0, irq_clr = 1'b0, ovf_clr = 1'b0;
  logic level_we = 1'b0;
  logic [4:0] level_wdata = '0;
  logic push = 1'b0, pop = 1'b0;
  logic [7:0] push_data = '0;

  logic [4:0] rx_lvl, tx_lvl, rx_fill, tx_fill;
  logic [7:0] rx_pd, tx_pd;
  logic rx_space, tx_space, rx_ovf, tx_ovf, rx_irq, tx_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  char_fifo_irq #(.IS_TX(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .fifo_run(fifo_run), .dir_en(dir_en), .irq_en(irq_en),
    .irq_clr(irq_clr), .ovf_clr(ovf_clr), .level_we(level_we), .level_wdata(level_wdata),
    .level_q(rx_lvl), .push(push), .push_data(push_data), .pop(pop), .pop_data(rx_pd),
    .fill(rx_fill), .space_ok(rx_space), .ovf_flag(rx_ovf), .irq(rx_irq));

  char_fifo_irq #(.IS_TX(1'b1)) dut_tx (
    .clk(clk), .rst_n(rst_n), .fifo_run(fifo_run), .dir_en(dir_en), .irq_en(irq_en),
    .irq_clr(irq_clr), .ovf_clr(ovf_clr), .level_we(level_we), .level_wdata(level_wdata),
    .level_q(tx_lvl), .push(push), .push_data(push_data), .pop(pop), .pop_data(tx_pd),
    .fill(tx_fill), .space_ok(tx_space), .ovf_flag(tx_ovf), .irq(tx_irq));

  int checks = 0, failures = 0;
  bit finished = 0;

  // Reference model state
  logic [7:0] mq[$];
  int  m_last = 0, m_rlvl = 31, m_tlvl = 0;
  bit  m_ovf = 0, m_rflag = 0, m_tflag = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3 fill", int'(rx_fill), mq.size());
    chk("R3 space_ok", int'(rx_space), (mq.size() < DEPTH) ? 1 : 0);
    chk("R2 pop_data", int'(rx_pd), m_last);
    chk("R4 ovf_flag", int'(rx_ovf), int'(m_ovf));
    chk("R9 R11 rx irq", int'(rx_irq), int'(m_rflag && irq_en));
    chk("R10 R11 tx irq", int'(tx_irq), int'(m_tflag && irq_en));
    chk("R12 level_q", int'(rx_lvl), m_rlvl);
  endtask

  // One clock: drive strobes, update model at the edge, compare at negedge.
  task automatic step(bit p, logic [7:0] d, bit q);
    int cnt0;
    bit popok, pushok, ovfev;
    push = p; push_data = d; pop = q;
    cnt0   = mq.size();
    popok  = fifo_run && dir_en && q && (cnt0 > 0);
    pushok = fifo_run && dir_en && p && (cnt0 < DEPTH || popok);
    ovfev  = fifo_run && dir_en && p && (cnt0 == DEPTH) && !popok;
    @(posedge clk);
    if (!fifo_run) begin
      mq.delete(); m_ovf = 0; m_rflag = 0; m_tflag = 0;
    end else begin
      if (popok) m_last = int'(mq.pop_front());
      if (pushok) mq.push_back(d);
      if (ovfev) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
      if (irq_clr) begin m_rflag = 0; m_tflag = 0; end
      else begin
        if (cnt0 >= m_rlvl) m_rflag = 1;
        if (cnt0 <= m_tlvl) m_tflag = 1;
      end
    end
    if (level_we) begin m_rlvl = int'(level_wdata); m_tlvl = int'(level_wdata); end
    @(negedge clk);
    compare_all();
    push = 0; pop = 0; irq_clr = 0; ovf_clr = 0; level_we = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 fill", int'(rx_fill), 0);
    chk("R1 space_ok", int'(rx_space), 1);
    chk("R1 ovf", int'(rx_ovf), 0);
    chk("R1 irq", int'(rx_irq), 0);
    chk("R1 pop_data", int'(rx_pd), 0);
    chk("R1 rx level", int'(rx_lvl), 31);
    chk("R1 tx level", int'(tx_lvl), 0);
    rst_n = 1'b1;
    @(negedge clk);
    fifo_run = 1; dir_en = 1; irq_en = 1;

    // Fill to full with the reset threshold: rx never flags (R9)
    for (int i = 0; i < DEPTH; i++) step(1, 8'(8'h40 + i), 0);
    chk("R9 reset level no irq", int'(rx_irq), 0);
    // R4 overflow, then clear racing a second overflow, then plain clear
    step(1, 8'hEE, 0);
    chk("R4 ovf set", int'(rx_ovf), 1);
    ovf_clr = 1; step(1, 8'hEF, 0);
    chk("R4 ovf set wins over clear", int'(rx_ovf), 1);
    ovf_clr = 1; step(0, 8'h00, 0);
    chk("R4 ovf cleared", int'(rx_ovf), 0);
    // R6 push+pop at full
    step(1, 8'h99, 1);
    chk("R6 full both fill", int'(rx_fill), 16);
    chk("R6 full both no ovf", int'(rx_ovf), 0);
    chk("R6 full both data", int'(rx_pd), 8'h40);
    // R2 drain in order
    for (int i = 0; i < DEPTH; i++) step(0, 8'h00, 1);
    chk("R2 last drained", int'(rx_pd), 8'h99);
    // R5 pop from empty
    step(0, 8'h00, 1);
    chk("R5 data kept", int'(rx_pd), 8'h99);
    chk("R5 fill kept", int'(rx_fill), 0);
    // R6 push+pop at empty
    step(1, 8'h5A, 1);
    chk("R6 empty both fill", int'(rx_fill), 1);
    chk("R6 empty both data", int'(rx_pd), 8'h99);
    // R7 disabled
    dir_en = 0;
    step(1, 8'h11, 0); step(0, 8'h00, 1);
    chk("R7 disabled fill", int'(rx_fill), 1);
    chk("R7 disabled data", int'(rx_pd), 8'h99);
    dir_en = 1;

    // R9 R10 R11 threshold sweep with interleaved clears and mask changes
    for (int lv = 0; lv <= DEPTH; lv++) begin
      level_we = 1; level_wdata = 5'(lv);
      step(0, 8'h00, 0);
      for (int k = 0; k < 2 * DEPTH + 4; k++) begin
        irq_clr = (k % 5 == 2);
        irq_en  = (k % 7 != 3);
        if (k < DEPTH + 2) step(1, 8'(lv * 17 + k), (k % 6 == 5));
        else               step((k % 4 == 0), 8'(k), 1);
      end
    end

    // R11 clear while condition holds: low one cycle, then sets again
    irq_en = 1;
    level_we = 1; level_wdata = 5'd0; step(0, 8'h00, 0);
    step(0, 8'h00, 0);
    irq_clr = 1; step(0, 8'h00, 0);
    chk("R11 cleared", int'(rx_irq), 0);
    step(0, 8'h00, 0);
    chk("R11 sets again", int'(rx_irq), 1);

    // R8 hold-in-clear, threshold kept
    level_we = 1; level_wdata = 5'd9; step(0, 8'h00, 0);
    for (int i = 0; i < DEPTH + 1; i++) step(1, 8'(i), 0);
    fifo_run = 0;
    step(1, 8'h77, 0);
    chk("R8 fill cleared", int'(rx_fill), 0);
    chk("R8 ovf cleared", int'(rx_ovf), 0);
    chk("R8 irq cleared", int'(rx_irq), 0);
    step(1, 8'h78, 1);
    chk("R8 push ignored", int'(rx_fill), 0);
    level_we = 1; level_wdata = 5'd3; step(0, 8'h00, 0);
    chk("R12 level load while held", int'(rx_lvl), 3);
    fifo_run = 1;
    step(1, 8'h21, 0); step(1, 8'h22, 0); step(0, 8'h00, 1);
    chk("R2 after release", int'(rx_pd), 8'h21);

    finish_run();
  end
endmodule